// File: doc/BRIEF.md
# Odd-Harmonic Repetitive Control Datapath

This block is the per-sample arithmetic core of a plug-in repetitive controller that cancels odd harmonics of a periodic disturbance. Each time the sample strobe is asserted, it takes one signed current-error sample. It then produces one signed control correction and stores one new word in a circular history that spans half a fundamental cycle. With 320 samples per cycle, that history is 160 words.

For sample i the output is a zero-phase three-tap low-pass of the stored history. The taps are read at sample indices i+M−H−1, i+M−H and i+M−H+1, where H = 160 is the half-cycle length and M = 3 is the phase-lead offset. The lead is therefore folded directly into the read addresses. The word written for sample i is the scaled error minus the output produced M samples earlier. This subtraction gives the sign inversion on every half cycle, so that only odd harmonics are reinforced. The proportional path, feedforward, plant and PWM logic sit outside the block.

Top module: `odd_rep_ctrl`

## Requirements
- R1: After reset (rst_n low) or a synchronous clear (clr high at a clock edge), ctl_out is 0 and ctl_vld is 0. clr takes priority over smp_stb in the same cycle.
- R2: For the i-th accepted sample, ctl_out = floor((w[i+M−H−1] + 2·w[i+M−H] + w[i+M−H+1]) / 4), with H = 160 and M = 3. A history word for a sample index below 0 counts as 0.
- R3: The history word is w[i] = sat16(floor(err_in·11469 / 4096) − y[i−M]). The gain is 2.8 in signed Q4.12 format, y[i−M] is the output produced M samples earlier, and y of a negative index is 0.
- R4: After reset or clear, the first 156 accepted samples (i = 0..155) give ctl_out = 0 for any error input. Sample 156 is the first one that can be nonzero.
- R5: ctl_vld is high for exactly the one cycle that follows each accepted strobe, and low otherwise. ctl_out takes its new value in that same cycle.
- R6: The history word saturates to the range −32768..32767. A constant error of +20000 from a clear gives outputs 8191, 24575 and 32767 at samples 156, 157 and 158. A constant error of −20000 gives −8192 at sample 156.
- R7: A clear in the middle of a run discards all history and all past outputs. The next samples follow R2 to R4 as if from reset.
- R8: In cycles without a strobe, ctl_out holds its value and no state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of history, output delay line and output |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| err_in | input | 16 | Signed current-error sample |
| ctl_out | output | 16 | Signed control correction |
| ctl_vld | output | 1 | High one cycle after each accepted sample |

## Verification
The assertions check, on every cycle, the strobe-to-valid timing, output hold between strobes, the effect of clear, the pointer wrap at the half-cycle boundary, and a zero output when all three taps are zero. Only the bench scenarios can show bit-exact equality of the two difference equations over several half cycles with a periodic odd-symmetric error. The same applies to saturation under large constant errors, the 156-sample zero window, and recovery after a clear in mid-run. For these, the bench compares every sample against an integer model built with floor division.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int SMP_W = 16;
  localparam int ACC_W = 32;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t SMP_MAX = acc_t'((1 << (SMP_W-1)) - 1);
  localparam acc_t SMP_MIN = -acc_t'(1 << (SMP_W-1));

  // clamp a wide value into the sample range
  function automatic smp_t sat_smp(input acc_t v);
    if (v > SMP_MAX) return smp_t'(SMP_MAX);
    if (v < SMP_MIN) return smp_t'(SMP_MIN);
    return smp_t'(v);
  endfunction

  // error times fixed-point gain, truncated toward minus infinity
  function automatic acc_t gain_mul(input smp_t e, input smp_t k, input int frac);
    acc_t p;
    p = acc_t'(e) * acc_t'(k);
    return p >>> frac;
  endfunction

  // zero-phase low-pass with weights 1/4, 1/2, 1/4
  function automatic smp_t q3tap(input smp_t lag, input smp_t mid, input smp_t lead);
    acc_t s;
    s = acc_t'(lag) + (acc_t'(mid) <<< 1) + acc_t'(lead);
    return sat_smp(s >>> 2);
  endfunction
endpackage

// File: rtl/rc_history.sv
module rc_history
  import rc_pkg::*;
#(
  parameter int DEPTH = 160,
  parameter int LEAD  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  smp_t wr_data,
  output smp_t tap_lag,
  output smp_t tap_mid,
  output smp_t tap_lead
);
  localparam int PW = $clog2(DEPTH);

  smp_t          mem [DEPTH];
  logic [PW-1:0] wptr;
  smp_t          taps [3];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      wptr <= '0;
    end else if (wr_en) begin
      mem[wptr] <= wr_data;
      wptr <= (int'(wptr) == DEPTH-1) ? '0 : wptr + 1'b1;
    end
  end

  // slot of sample i+LEAD-DEPTH+d-1 is (wptr + LEAD + d - 1) mod DEPTH
  for (genvar d = 0; d < 3; d++) begin : g_tap
    localparam int OFS = (LEAD + d - 1 + DEPTH) % DEPTH;
    int unsigned addr;
    always_comb begin
      addr = int'(wptr) + OFS;
      if (addr >= DEPTH) addr = addr - DEPTH;
      taps[d] = mem[addr[PW-1:0]];
    end
  end

  assign tap_lag  = taps[0];
  assign tap_mid  = taps[1];
  assign tap_lead = taps[2];

  a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wptr) < DEPTH);
  a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr && int'(wptr) == DEPTH-1 |=> wptr == '0);
endmodule

// File: rtl/rc_out_delay.sv
module rc_out_delay
  import rc_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sh_en,
  input  smp_t y_in,
  output smp_t y_old
);
  if (DEPTH == 0) begin : g_none
    assign y_old = y_in;
  end else begin : g_line
    smp_t line [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        for (int k = 0; k < DEPTH; k++) line[k] <= '0;
      end else if (sh_en) begin
        line[0] <= y_in;
        for (int k = 1; k < DEPTH; k++) line[k] <= line[k-1];
      end
    end
    assign y_old = line[DEPTH-1];
  end
endmodule

// File: rtl/odd_rep_ctrl.sv
module odd_rep_ctrl
  import rc_pkg::*;
#(
  parameter int          HALF    = 160,
  parameter int          LEAD    = 3,
  parameter int          KR_FRAC = 12,
  parameter logic [15:0] KR_GAIN = 16'd11469
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_stb,
  input  logic signed [15:0] err_in,
  output logic signed [15:0] ctl_out,
  output logic              ctl_vld
);
  smp_t tap_lag, tap_mid, tap_lead;
  smp_t y_next, y_old, w_new;
  logic accept;

  assign accept = smp_stb && !clr;

  rc_history #(.DEPTH(HALF), .LEAD(LEAD)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(accept), .wr_data(w_new),
    .tap_lag(tap_lag), .tap_mid(tap_mid), .tap_lead(tap_lead)
  );

  rc_out_delay #(.DEPTH(LEAD)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sh_en(accept),
    .y_in(y_next), .y_old(y_old)
  );

  assign y_next = q3tap(tap_lag, tap_mid, tap_lead);
  assign w_new  = sat_smp(gain_mul(err_in, smp_t'(KR_GAIN), KR_FRAC) - acc_t'(y_old));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ctl_out <= '0;
      ctl_vld <= 1'b0;
    end else begin
      ctl_vld <= smp_stb;
      if (smp_stb) ctl_out <= y_next;
    end
  end

  a_r5_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ctl_vld);
  a_r5_vld_only_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !ctl_vld);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb && !clr |=> $stable(ctl_out));
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ctl_out == '0 && !ctl_vld);
  a_r4_zero_taps: assert property (@(posedge clk) disable iff (!rst_n)
    accept && tap_lag == '0 && tap_mid == '0 && tap_lead == '0 |=> ctl_out == '0);
endmodule

// File: tb/odd_rep_ctrl_test.sv
module odd_rep_ctrl_test;
  localparam int H = 160;
  localparam int M = 3;
  localparam int KR = 11469;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [15:0] err_in = '0;
  logic signed [15:0] ctl_out;
  logic ctl_vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int wr [0:1023];
  int yr [0:1023];
  int n = 0;

  always #2.5 clk = ~clk;

  odd_rep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_stb(smp_stb),
    .err_in(err_in), .ctl_out(ctl_out), .ctl_vld(ctl_vld)
  );

  function automatic int fdiv(int s, int d);
    int q = s / d;
    if (s < 0 && (s % d) != 0) q = q - 1;
    return q;
  endfunction

  function automatic int clamp(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int wget(int j);
    return (j < 0) ? 0 : wr[j];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample: strobe, then two idle cycles; returns expected output
  task automatic sample(int e, output int y);
    int b = n + M - H;
    y = fdiv(wget(b-1) + 2*wget(b) + wget(b+1), 4);
    wr[n] = clamp(fdiv(e * KR, 4096) - ((n >= M) ? yr[n-M] : 0));
    yr[n] = y;
    @(negedge clk);
    smp_stb = 1'b1; err_in = 16'(e);
    @(negedge clk);
    smp_stb = 1'b0;
    chk("R2/R3 output", int'(ctl_out), y);
    chk("R5 valid high", int'(ctl_vld), 1);
    @(negedge clk);
    chk("R5 valid low", int'(ctl_vld), 0);
    chk("R8 hold", int'(ctl_out), y);
    n++;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; smp_stb = 1'b1; err_in = 16'sd1234;
    @(negedge clk);
    clr = 1'b0; smp_stb = 1'b0;
    chk("R1 clear output", int'(ctl_out), 0);
    chk("R1 clear valid", int'(ctl_vld), 0);
    n = 0;
  endtask

  function automatic int tri_wave(int p);
    int q = p % 160;
    int t = (q < 80) ? q * 40 : (160 - q) * 40;
    return ((p % 320) < 160) ? t : -t;
  endfunction

  initial begin
    int y;
    repeat (3) @(negedge clk);
    chk("R1 reset output", int'(ctl_out), 0);
    chk("R1 reset valid", int'(ctl_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'(ctl_out), 0);

    // periodic odd-symmetric error over several half cycles
    for (int i = 0; i < 700; i++) begin
      sample(tri_wave(i) + ((i % 7) - 3), y);
      if (i == 155) chk("R4 last zero sample", y, 0);
    end

    // mid-run clear, then positive saturation
    do_clear();
    for (int i = 0; i < 200; i++) begin
      sample(20000, y);
      if (i < 156) chk("R4/R7 zero window", int'(ctl_out), 0);
      if (i == 156) chk("R6 sample 156", int'(ctl_out), 8191);
      if (i == 157) chk("R6 sample 157", int'(ctl_out), 24575);
      if (i == 158) chk("R6 sample 158", int'(ctl_out), 32767);
    end

    // negative saturation
    do_clear();
    for (int i = 0; i < 170; i++) begin
      sample(-20000, y);
      if (i == 156) chk("R6 negative sample 156", int'(ctl_out), -8192);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule